// File: doc/BRIEF.md
# Sleep Entry and Recovery Controller

This block governs a low-power sleep state of a synchronous memory. A sleep request arrives on a pin that has no timing relation to the clock. The block passes it through a synchroniser. It then spends a fixed number of cycles entering sleep and the same kind of fixed window recovering after the request is released. Outside the awake state, array writes and new accesses are blocked and the data outputs are held in high impedance. Because writes are blocked, stored contents stay unchanged across the sleep period.

Any access that is still pending when entry begins is abandoned, because the gating applies from the first entry cycle. The host must deselect the memory before it requests sleep. It must also keep the chip select and both address strobes idle through the recovery window. The block watches both rules and raises a sticky violation flag when either one is broken. Only a reset clears that flag.

Top module: `slp_ctrl`

## Requirements
- R1: After reset, core_ready is 1, and sleep_active, recovering, out_hiz and proto_err are all 0.
- R2: A change on sleep_req has no effect on the state outputs until it has crossed two synchroniser flops. After sleep_req rises, core_ready stays 1 through the first two rising edges.
- R3: On the third rising edge after sleep_req rises, the block enters a 2-cycle entry window in which core_ready=0, sleep_active=0 and out_hiz=1. sleep_active becomes 1 on the fifth edge.
- R4: While core_ready is 0, wr_en_o and acc_start_o are 0 and out_hiz is 1. While core_ready is 1, wr_en_o follows wr_req, acc_start_o is chip_sel AND (strobe_a OR strobe_b), and out_hiz is 0.
- R5: When sleep_req falls during sleep, recovering becomes 1 on the third edge and stays 1 for exactly 2 cycles. After that, core_ready returns to 1.
- R6: Entry cannot be cancelled once it starts. If the request is withdrawn during the entry window, sleep_active is still 1 for one cycle, and then a normal recovery follows.
- R7: If chip_sel, strobe_a or strobe_b is 1 on any edge while recovering is 1, proto_err is set after that edge and stays 1 until reset.
- R8: If chip_sel is 1 on the edge where the synchronised request first starts entry, proto_err is set after that edge.
- R9: A recovery with all selects and strobes idle, followed by accesses once core_ready is 1, leaves proto_err at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| chip_sel | input | 1 | Combined chip enable, active high |
| strobe_a | input | 1 | First address strobe, active high |
| strobe_b | input | 1 | Second address strobe, active high |
| wr_req | input | 1 | Array write request from the access logic |
| wr_en_o | output | 1 | Gated array write enable |
| acc_start_o | output | 1 | Gated access start |
| out_hiz | output | 1 | Force data outputs to high impedance |
| core_ready | output | 1 | Block awake and accepting accesses |
| sleep_active | output | 1 | Sleep state reached; gates the core |
| recovering | output | 1 | Exit recovery window in progress |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
Each state output changes on the third rising edge after a request edge. That is two edges for the synchroniser and one for the state register. sleep_active follows on the fifth edge, and core_ready returns on the fifth edge after release. proto_err appears one edge after the offending cycle, while the gated write and access outputs follow their inputs in the same cycle. The bench drives inputs and samples outputs 1 ns after a rising edge. It counts edges from each stimulus and checks each output on both sides of the edge where it is due to change, so an extra or missing stage shows up as a mismatch.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_ENTER  = 2'd1,
        ST_ASLEEP = 2'd2,
        ST_EXIT   = 2'd3
    } slp_state_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign chain_d[i] = async_i;
            end else begin : g_next
                assign chain_d[i] = chain_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
#(
    parameter int ENTER_CYC = 2,
    parameter int EXIT_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s,
    input  logic       sel,
    input  logic       any_acc,
    output slp_state_e state_o,
    output logic       err_o
);
    localparam int MAXC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
    localparam int CW   = $clog2(MAXC) + 1;
    localparam logic [CW-1:0] ENT_LOAD = CW'(ENTER_CYC - 1);
    localparam logic [CW-1:0] EXT_LOAD = CW'(EXIT_CYC - 1);

    typedef struct packed {
        slp_state_e    st;
        logic [CW-1:0] cnt;
        logic          err;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.st)
            ST_AWAKE: begin
                if (req_s) begin
                    fsm_d.st  = ST_ENTER;
                    fsm_d.cnt = ENT_LOAD;
                    if (sel) fsm_d.err = 1'b1;
                end
            end
            ST_ENTER: begin
                if (fsm_q.cnt == '0) fsm_d.st = ST_ASLEEP;
                else                 fsm_d.cnt = fsm_q.cnt - 1'b1;
            end
            ST_ASLEEP: begin
                if (!req_s) begin
                    fsm_d.st  = ST_EXIT;
                    fsm_d.cnt = EXT_LOAD;
                end
            end
            ST_EXIT: begin
                if (any_acc) fsm_d.err = 1'b1;
                if (fsm_q.cnt == '0) fsm_d.st = ST_AWAKE;
                else                 fsm_d.cnt = fsm_q.cnt - 1'b1;
            end
            default: fsm_d.st = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st  <= ST_AWAKE;
            fsm_q.cnt <= '0;
            fsm_q.err <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.st;
    assign err_o   = fsm_q.err;
endmodule

// File: rtl/slp_gate.sv
module slp_gate
    import slp_pkg::*;
(
    input  slp_state_e state_i,
    input  logic       wr_req,
    input  logic       chip_sel,
    input  logic       strobe_a,
    input  logic       strobe_b,
    output logic       wr_en_o,
    output logic       acc_start_o,
    output logic       out_hiz,
    output logic       core_ready,
    output logic       sleep_active,
    output logic       recovering
);
    logic awake;

    always_comb begin
        awake        = (state_i == ST_AWAKE);
        core_ready   = awake;
        sleep_active = (state_i == ST_ASLEEP);
        recovering   = (state_i == ST_EXIT);
        out_hiz      = !awake;
        wr_en_o      = awake & wr_req;
        acc_start_o  = awake & chip_sel & (strobe_a | strobe_b);
    end
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTER_CYC   = 2,
    parameter int EXIT_CYC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic chip_sel,
    input  logic strobe_a,
    input  logic strobe_b,
    input  logic wr_req,
    output logic wr_en_o,
    output logic acc_start_o,
    output logic out_hiz,
    output logic core_ready,
    output logic sleep_active,
    output logic recovering,
    output logic proto_err
);
    logic       req_s;
    logic       any_acc;
    slp_state_e state;

    assign any_acc = chip_sel | strobe_a | strobe_b;

    slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sleep_req),
        .sync_o  (req_s)
    );

    slp_fsm #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_s   (req_s),
        .sel     (chip_sel),
        .any_acc (any_acc),
        .state_o (state),
        .err_o   (proto_err)
    );

    slp_gate u_gate (
        .state_i      (state),
        .wr_req       (wr_req),
        .chip_sel     (chip_sel),
        .strobe_a     (strobe_a),
        .strobe_b     (strobe_b),
        .wr_en_o      (wr_en_o),
        .acc_start_o  (acc_start_o),
        .out_hiz      (out_hiz),
        .core_ready   (core_ready),
        .sleep_active (sleep_active),
        .recovering   (recovering)
    );
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic chip_sel,
    input logic strobe_a,
    input logic strobe_b,
    input logic wr_en_o,
    input logic acc_start_o,
    input logic out_hiz,
    input logic core_ready,
    input logic sleep_active,
    input logic recovering,
    input logic proto_err
);
    AST_SLEEP_VIA_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_active) |-> $past(out_hiz && !core_ready && !recovering)); // R3
    AST_GATED_WHEN_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_active || recovering) |-> (!wr_en_o && !acc_start_o && out_hiz)); // R4
    AST_READY_AFTER_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(recovering) |-> core_ready); // R5
    AST_STATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sleep_active, recovering, core_ready})); // R5
    AST_RECOVERY_ACCESS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (recovering && (chip_sel || strobe_a || strobe_b)) |=> proto_err); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R7
endmodule

bind slp_ctrl slp_ctrl_chk u_chk (.*);

// File: tb/slp_ctrl_bench.sv
`timescale 1ns/1ps
module slp_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, chip_sel = 1'b0, strobe_a = 1'b0, strobe_b = 1'b0, wr_req = 1'b0;
    logic wr_en_o, acc_start_o, out_hiz, core_ready, sleep_active, recovering, proto_err;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    slp_ctrl u_slp_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .chip_sel(chip_sel),
        .strobe_a(strobe_a), .strobe_b(strobe_b), .wr_req(wr_req),
        .wr_en_o(wr_en_o), .acc_start_o(acc_start_o), .out_hiz(out_hiz),
        .core_ready(core_ready), .sleep_active(sleep_active),
        .recovering(recovering), .proto_err(proto_err)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        {sleep_req, chip_sel, strobe_a, strobe_b, wr_req} = '0;
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 core_ready", core_ready, 1'b1);
        chk("R1 sleep_active", sleep_active, 1'b0);
        chk("R1 recovering", recovering, 1'b0);
        chk("R1 out_hiz", out_hiz, 1'b0);
        chk("R1 proto_err", proto_err, 1'b0);
    endtask

    task automatic t_entry_and_exit();
        do_reset();
        wr_req = 1'b1; chip_sel = 1'b1; strobe_a = 1'b1; #0.5;
        chk("R4 awake wr_en", wr_en_o, 1'b1);
        chk("R4 awake acc_start", acc_start_o, 1'b1);
        chip_sel = 1'b0; strobe_a = 1'b0; wr_req = 1'b0;
        sleep_req = 1'b1;
        step(1); chk("R2 edge1 ready", core_ready, 1'b1);
        step(1); chk("R2 edge2 ready", core_ready, 1'b1);
        step(1);
        chk("R3 entering ready", core_ready, 1'b0);
        chk("R3 entering sleep", sleep_active, 1'b0);
        chk("R3 entering hiz", out_hiz, 1'b1);
        wr_req = 1'b1; #0.5;
        chk("R4 entering wr_en", wr_en_o, 1'b0);
        step(1); chk("R3 entry cycle2 sleep", sleep_active, 1'b0);
        step(1); chk("R3 asleep", sleep_active, 1'b1);
        chip_sel = 1'b1; strobe_b = 1'b1; #0.5;
        chk("R4 asleep wr_en", wr_en_o, 1'b0);
        chk("R4 asleep acc_start", acc_start_o, 1'b0);
        chk("R4 asleep hiz", out_hiz, 1'b1);
        chip_sel = 1'b0; strobe_b = 1'b0; wr_req = 1'b0;
        sleep_req = 1'b0;
        step(2); chk("R5 still asleep", sleep_active, 1'b1);
        step(1); chk("R5 recovering 1", recovering, 1'b1);
        step(1); chk("R5 recovering 2", recovering, 1'b1);
        chk("R5 not ready in window", core_ready, 1'b0);
        step(1);
        chk("R5 ready", core_ready, 1'b1);
        chk("R5 window closed", recovering, 1'b0);
        chk("R9 clean recovery err", proto_err, 1'b0);
        chip_sel = 1'b1; strobe_a = 1'b1; wr_req = 1'b1; #0.5;
        chk("R4 after wake wr_en", wr_en_o, 1'b1);
        chk("R4 after wake hiz", out_hiz, 1'b0);
        step(2);
        chk("R9 access after wake err", proto_err, 1'b0);
        chip_sel = 1'b0; strobe_a = 1'b0; wr_req = 1'b0;
    endtask

    task automatic t_commit();
        do_reset();
        sleep_req = 1'b1;
        step(3);
        chk("R6 entry started", core_ready, 1'b0);
        sleep_req = 1'b0;
        step(1); chk("R6 not yet asleep", sleep_active, 1'b0);
        step(1); chk("R6 asleep once", sleep_active, 1'b1);
        step(1);
        chk("R6 left sleep", sleep_active, 1'b0);
        chk("R6 recovering", recovering, 1'b1);
        step(2); chk("R6 ready again", core_ready, 1'b1);
        chk("R6 no error", proto_err, 1'b0);
    endtask

    task automatic t_recovery_violation();
        do_reset();
        sleep_req = 1'b1;
        step(5);
        chk("R7 asleep", sleep_active, 1'b1);
        sleep_req = 1'b0;
        step(3);
        chk("R7 in window", recovering, 1'b1);
        chk("R7 err before", proto_err, 1'b0);
        strobe_b = 1'b1;
        step(1); chk("R7 err set", proto_err, 1'b1);
        strobe_b = 1'b0;
        step(4); chk("R7 err sticky", proto_err, 1'b1);
        chk("R7 awake", core_ready, 1'b1);
        do_reset();
        chk("R1 err cleared", proto_err, 1'b0);
    endtask

    task automatic t_select_violation();
        do_reset();
        chip_sel = 1'b1;
        sleep_req = 1'b1;
        step(2); chk("R8 err before entry", proto_err, 1'b0);
        step(1); chk("R8 err on entry", proto_err, 1'b1);
        chip_sel = 1'b0;
        do_reset();
        sleep_req = 1'b1;
        step(3);
        chip_sel = 1'b1;
        step(1); chk("R8 select after entry no err", proto_err, 1'b0);
        chip_sel = 1'b0;
    endtask

    initial begin
        t_reset();
        t_entry_and_exit();
        t_commit();
        t_recovery_violation();
        t_select_violation();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule